// File: doc/BRIEF.md
# Prediction-Gated Residue Modular Adder

This block adds two residues of one residue-number channel and returns their sum reduced by the channel modulus `MOD`. It is used where a wide integer datapath has been split into several narrow channels that run in parallel, each with its own small modulus. In the general case two candidate sums are built side by side: the plain sum `a + b` and the corrected sum `a + b - MOD`. The corrected sum is formed by a carry-save stage that folds in the constant `2^n - MOD`, followed by one carry-propagate adder. The carry-out of that adder, inverted, gives the sign of `a + b - MOD`.

To cut switching activity, a small predictor looks only at the upper operand bits. It decides whether the plain path alone, the corrected path alone, or both are needed. Each path has level-sensitive latches on its operand inputs, and these latches are open only while that path is enabled. A path that is switched off keeps its previous operands, so its adder does not toggle. The predictor is conservative: when it enables a single path, that path is always the one the exact sign would have chosen. When both paths run, the true sign picks the result. The chosen sum is registered, so it appears one clock edge after the operands are applied.

Two moduli get a cheaper structure with no gating. For `MOD = 2^n`, a single n-bit adder is used and its carry is discarded. For `MOD = 2^n - 1`, two n-bit adders run, one with carry-in 0 and one with carry-in 1. The predictor's enables and the two path sums are also brought out at the ports, so the gating can be observed.

Top module: `modadd_gate`

## Requirements
- R1: While `rstN` is low, `sumOut` is 0 whatever the operands.
- R2: `opA` and `opB` are n = ceil(log2 MOD) bits wide and always hold values from 0 to MOD-1; the pair (MOD-1, MOD-1) is handled like any other.
- R3: After each rising edge with `rstN` high, `sumOut` equals (opA + opB) mod MOD for the operands present before that edge.
- R4: General modulus: while the plain path is enabled, `plainPath` equals the low n bits of opA + opB. While the corrected path is enabled, `subPath` equals the low n bits of opA + opB + 2^n - MOD. When both are enabled, a carry-out of 1 from the corrected sum selects `subPath`, and a carry-out of 0 selects `plainPath`.
- R5: General modulus: let k = n-2 (k = 0 when n ≤ 2), h = (opA >> k) + (opB >> k), lo = h·2^k and hi = lo + 2·(2^k − 1). Then `runPlainOut` is 0 exactly when lo ≥ MOD, and `runSubOut` is 0 exactly when hi < MOD.
- R6: Whenever `runPlainOut` is 1 and `runSubOut` is 0, opA + opB < MOD.
- R7: Whenever `runSubOut` is 1 and `runPlainOut` is 0, opA + opB ≥ MOD. At least one of the two enables is 1 at all times.
- R8: While a path is disabled, its latched operands and its path sum (`plainPath` or `subPath`) keep the value they had at the previous sample.
- R9: MOD = 2^n: both enables are 1, and `sumOut` is the low n bits of opA + opB.
- R10: MOD = 2^n − 1: both enables are 1. The result is the carry-in-1 sum when that sum carries out, and the carry-in-0 sum otherwise, so zero is always shown as 0 and never as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rstN | input | 1 | Active-low reset; clears the result register and the path latches |
| opA | input | N | First residue, 0..MOD-1 |
| opB | input | N | Second residue, 0..MOD-1 |
| sumOut | output | N | Registered (opA + opB) mod MOD |
| runPlainOut | output | 1 | Plain-sum path enabled by the predictor |
| runSubOut | output | 1 | Corrected-sum path enabled by the predictor |
| plainPath | output | N | Low n bits of the plain path's sum |
| subPath | output | N | Low n bits of the corrected path's sum |

## Verification
The assertions assume that both operands are already reduced below MOD and that they change only away from the rising edge. If either assumption fails, the conservative-prediction and hold checks lose their meaning. The stimulus drives operands only on falling edges. Every value is drawn as an index below the lane's modulus: first an exhaustive sweep over all pairs, then `$urandom` values reduced modulo MOD. Five lanes run in parallel, one each for moduli 11, 13, 29, 16 and 15, so the general, power-of-two and all-ones variants are all covered.

// File: rtl/modadd_pkg.sv
package modadd_pkg;

  // Structural flavour chosen from the modulus
  typedef enum logic [1:0] {
    VAR_GENERAL = 2'd0,
    VAR_POW2    = 2'd1,
    VAR_ALLONES = 2'd2
  } modVariant_e;

  // Strobes from the predictor to the datapath
  typedef struct packed {
    logic runPlain;   // open latches of the a+b path
    logic runSub;     // open latches of the a+b-m path
    logic trustSign;  // both paths live: select by the computed sign
  } pathCtrl_t;

  function automatic modVariant_e pickVariant(input int unsigned m, input int unsigned n);
    if ((32'd1 << n) == m)               return VAR_POW2;
    else if (((32'd1 << n) - 32'd1) == m) return VAR_ALLONES;
    else                                  return VAR_GENERAL;
  endfunction

endpackage

// File: rtl/modadd_predict.sv
module modadd_predict
  import modadd_pkg::*;
#(
  parameter int unsigned MOD = 11,
  parameter int unsigned N = $clog2(MOD),
  parameter modVariant_e VARIANT = VAR_GENERAL
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output pathCtrl_t    ctrl
);
  timeunit 1ns;
  timeprecision 1ps;

  // Operands must already be reduced residues
  a_r2_operand_range: assert property (@(posedge clk) disable iff (!rstN)
    (32'(opA) < MOD) && (32'(opB) < MOD));

  if (VARIANT == VAR_GENERAL) begin : genPredict
    localparam int unsigned SHIFT = (N > 2) ? N - 2 : 0;
    localparam int unsigned HI_W  = N - SHIFT;
    localparam int unsigned SLACK = 2 * ((32'd1 << SHIFT) - 1);

    logic [HI_W:0] hiSum;
    logic [N+1:0]  lowBound;
    logic [N+1:0]  highBound;
    logic          fitsPlain;
    logic          needsSub;
    logic [N:0]    trueSum;

    always_comb begin
      hiSum     = {1'b0, opA[N-1:SHIFT]} + {1'b0, opB[N-1:SHIFT]};
      lowBound  = {{(N+1-HI_W){1'b0}}, hiSum} << SHIFT;
      highBound = lowBound + (N+2)'(SLACK);
      fitsPlain = highBound < (N+2)'(MOD);
      needsSub  = lowBound >= (N+2)'(MOD);
      ctrl.runPlain  = !needsSub;
      ctrl.runSub    = !fitsPlain;
      ctrl.trustSign = !needsSub && !fitsPlain;
    end

    assign trueSum = {1'b0, opA} + {1'b0, opB};

    a_r6_plain_only_safe: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.runPlain && !ctrl.runSub) |-> (32'(trueSum) < MOD));

    a_r7_sub_only_safe: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.runSub && !ctrl.runPlain) |-> (32'(trueSum) >= MOD));

    a_r7_path_live: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.runPlain || ctrl.runSub);

  end else begin : genUngated
    always_comb begin
      ctrl.runPlain  = 1'b1;
      ctrl.runSub    = 1'b1;
      ctrl.trustSign = 1'b0;
    end
  end

endmodule

// File: rtl/modadd_datapath.sv
module modadd_datapath
  import modadd_pkg::*;
#(
  parameter int unsigned MOD = 11,
  parameter int unsigned N = $clog2(MOD),
  parameter modVariant_e VARIANT = VAR_GENERAL
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  pathCtrl_t    ctrl,
  output logic [N-1:0] result,
  output logic [N-1:0] plainPath,
  output logic [N-1:0] subPath
);
  timeunit 1ns;
  timeprecision 1ps;

  if (VARIANT == VAR_GENERAL) begin : genGeneral
    localparam logic [N-1:0] NEG_M = N'((32'd1 << N) - MOD);

    logic [N-1:0] plainA, plainB, subA, subB;
    logic [N-1:0] plainSum;
    logic [N-1:0] csaSum;
    logic [N:0]   csaCarry;
    logic [N:0]   subFull;
    logic         isNeg;

    // Input latches of the a+b path: open only while enabled
    always_latch begin
      if (!rstN) begin
        plainA = '0;
        plainB = '0;
      end else if (ctrl.runPlain) begin
        plainA = opA;
        plainB = opB;
      end
    end

    // Input latches of the a+b-m path
    always_latch begin
      if (!rstN) begin
        subA = '0;
        subB = '0;
      end else if (ctrl.runSub) begin
        subA = opA;
        subB = opB;
      end
    end

    always_comb begin
      plainSum = plainA + plainB;
      csaSum   = subA ^ subB ^ NEG_M;
      csaCarry = {(subA & subB) | (subA & NEG_M) | (subB & NEG_M), 1'b0};
      subFull  = {1'b0, csaSum} + csaCarry;
      isNeg    = ~subFull[N];
      if (ctrl.trustSign) result = isNeg ? plainSum : subFull[N-1:0];
      else if (ctrl.runPlain) result = plainSum;
      else result = subFull[N-1:0];
    end

    assign plainPath = plainSum;
    assign subPath   = subFull[N-1:0];

    a_r8_hold_plain: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !ctrl.runPlain) |-> ($stable(plainA) && $stable(plainB)));

    a_r8_hold_sub: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !ctrl.runSub) |-> ($stable(subA) && $stable(subB)));

    a_r3_result_reduced: assert property (@(posedge clk) disable iff (!rstN)
      32'(result) < MOD);

  end else if (VARIANT == VAR_POW2) begin : genPow2
    logic [N-1:0] wrapSum;
    assign wrapSum   = opA + opB;
    assign result    = wrapSum;
    assign plainPath = wrapSum;
    assign subPath   = wrapSum;

    a_r9_pow2_ungated: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.runPlain && ctrl.runSub && !ctrl.trustSign);

  end else begin : genAllOnes
    logic [N-1:0] sumCin0;
    logic [N:0]   sumCin1;
    always_comb begin
      sumCin0 = opA + opB;
      sumCin1 = {1'b0, opA} + {1'b0, opB} + (N+1)'(1);
      result  = sumCin1[N] ? sumCin1[N-1:0] : sumCin0;
    end
    assign plainPath = sumCin0;
    assign subPath   = sumCin1[N-1:0];

    a_r10_allones_ungated: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.runPlain && ctrl.runSub && !ctrl.trustSign);

    a_r10_no_alias_zero: assert property (@(posedge clk) disable iff (!rstN)
      result != {N{1'b1}});
  end

endmodule

// File: rtl/modadd_gate.sv
module modadd_gate
  import modadd_pkg::*;
#(
  parameter int unsigned MOD = 11,
  localparam int unsigned N = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [N-1:0] sumOut,
  output logic         runPlainOut,
  output logic         runSubOut,
  output logic [N-1:0] plainPath,
  output logic [N-1:0] subPath
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam modVariant_e VARIANT = pickVariant(MOD, N);

  pathCtrl_t    ctrl;
  logic [N-1:0] nextSum;

  modadd_predict #(.MOD(MOD), .N(N), .VARIANT(VARIANT)) predictor (
    .clk  (clk),
    .rstN (rstN),
    .opA  (opA),
    .opB  (opB),
    .ctrl (ctrl)
  );

  modadd_datapath #(.MOD(MOD), .N(N), .VARIANT(VARIANT)) datapath (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .ctrl      (ctrl),
    .result    (nextSum),
    .plainPath (plainPath),
    .subPath   (subPath)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sumOut <= '0;
    else       sumOut <= nextSum;
  end

  assign runPlainOut = ctrl.runPlain;
  assign runSubOut   = ctrl.runSub;

  a_r3_registered_sum: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (32'(sumOut) == (32'($past(opA)) + 32'($past(opB))) % MOD));

endmodule

// File: tb/modadd_gate_test.sv
module modadd_gate_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LANES = 5;
  localparam int RANDOM_STEPS = 400;

  function automatic int unsigned laneMod(input int i);
    case (i)
      0: return 11;
      1: return 13;
      2: return 29;
      3: return 16;
      default: return 15;
    endcase
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] aIn [LANES];
  logic [4:0] bIn [LANES];
  logic [4:0] sumV [LANES];
  logic [4:0] pathP [LANES];
  logic [4:0] pathS [LANES];
  logic       runP [LANES];
  logic       runS [LANES];

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int prevP [LANES];
  int prevS [LANES];
  bit prevOk = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < LANES; i++) begin : lane
    localparam int unsigned M = laneMod(i);
    localparam int unsigned N = $clog2(M);
    logic [N-1:0] sumW, pW, sW;
    logic rp, rs;
    modadd_gate #(.MOD(M)) uut (
      .clk         (clk),
      .rstN        (rstN),
      .opA         (aIn[i][N-1:0]),
      .opB         (bIn[i][N-1:0]),
      .sumOut      (sumW),
      .runPlainOut (rp),
      .runSubOut   (rs),
      .plainPath   (pW),
      .subPath     (sW)
    );
    assign sumV[i]  = 5'(sumW);
    assign pathP[i] = 5'(pW);
    assign pathS[i] = 5'(sW);
    assign runP[i]  = rp;
    assign runS[i]  = rs;
  end

  task automatic check(input bit ok, input string req, input int i, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s m=%0d a=%0d b=%0d actual=%0d expected=%0d",
               req, laneMod(i), aIn[i], bIn[i], act, exp);
    end
  endtask

  task automatic checkLane(input int i);
    int m, n, mask, a, b, s, k, h, lo, hi, expSum;
    bit expP, expS, pow2, allOnes;
    string tag;
    m = int'(laneMod(i));
    n = $clog2(m);
    mask = (1 << n) - 1;
    a = int'(aIn[i]);
    b = int'(bIn[i]);
    s = a + b;
    expSum = s % m;
    pow2 = ((1 << n) == m);
    allOnes = ((1 << n) - 1 == m);
    tag = pow2 ? "R9" : (allOnes ? "R10" : "R3");
    if (a == m - 1 && b == m - 1) tag = "R2";
    check(int'(sumV[i]) == expSum, tag, i, int'(sumV[i]), expSum);
    if (pow2 || allOnes) begin
      check(runP[i] && runS[i], pow2 ? "R9" : "R10", i, {30'd0, runP[i], runS[i]}, 3);
      if (allOnes && s == m) check(sumV[i] == 5'd0, "R10", i, int'(sumV[i]), 0);
    end else begin
      k = (n > 2) ? n - 2 : 0;
      h = (a >> k) + (b >> k);
      lo = h << k;
      hi = lo + 2 * ((1 << k) - 1);
      expP = !(lo >= m);
      expS = !(hi < m);
      check(runP[i] == expP, "R5", i, int'(runP[i]), int'(expP));
      check(runS[i] == expS, "R5", i, int'(runS[i]), int'(expS));
      if (runP[i] && !runS[i]) check(s < m, "R6", i, s, m - 1);
      if (runS[i] && !runP[i]) check(s >= m, "R7", i, s, m);
      check(runP[i] || runS[i], "R7", i, 0, 1);
      if (runP[i]) check(int'(pathP[i]) == (s & mask), "R4", i, int'(pathP[i]), s & mask);
      if (runS[i]) check(int'(pathS[i]) == ((s + (1 << n) - m) & mask), "R4", i,
                         int'(pathS[i]), (s + (1 << n) - m) & mask);
      if (prevOk && !runP[i]) check(int'(pathP[i]) == prevP[i], "R8", i, int'(pathP[i]), prevP[i]);
      if (prevOk && !runS[i]) check(int'(pathS[i]) == prevS[i], "R8", i, int'(pathS[i]), prevS[i]);
    end
    prevP[i] = int'(pathP[i]);
    prevS[i] = int'(pathS[i]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < LANES; i++) begin
      aIn[i] = 5'(laneMod(i) - 1);
      bIn[i] = 5'(laneMod(i) - 1);
    end
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < LANES; i++) check(sumV[i] == 5'd0, "R1", i, int'(sumV[i]), 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int step = 0; step < 29 * 29 + RANDOM_STEPS; step++) begin
      @(negedge clk);
      for (int i = 0; i < LANES; i++) begin
        int m;
        m = int'(laneMod(i));
        if (step < m * m) begin
          aIn[i] = 5'(step / m);
          bIn[i] = 5'(step % m);
        end else begin
          aIn[i] = 5'($urandom % m);
          bIn[i] = 5'($urandom % m);
        end
      end
      @(posedge clk);
      #1;
      for (int i = 0; i < LANES; i++) checkLane(i);
      prevOk = 1'b1;
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule